// File: doc/BRIEF.md
# Timer Status Flags and Software Event Generation

This block is the flag and event logic of a 16-bit general-purpose up-counting timer. It holds one counter that wraps at a programmable reload value and four channels. Each channel either compares its register against the counter or latches the counter on an edge of its capture input. Sources in hardware raise the update, channel and trigger flags. Software clears those flags by writing zeros. Software can also raise them itself through a register of self-clearing event bits.

Software reaches the block over a simple single-cycle register bus. Writes are taken on the clock edge where `wrEn` is high. `rdData` is combinational from `addr`. Reading a capture register while `rdEn` is high has a side effect. Each flag drives a level interrupt output, gated by its own enable bit. An external trigger pulse restarts the counter in the same way as a software update event.

Top module: `tmrFlagEvt`

## Requirements
- R1: After reset the counter reads 0, the reload register reads 0xFFFF, the channel registers, status and control read 0, and every interrupt output is low.
- R2: In compare mode, while the counter runs, a cycle in which the counter equals the channel register sets that channel's flag at the next clock edge.
- R3: A compare channel whose register is greater than the reload value sets its flag on the cycle the counter wraps from the reload value to 0, and not before.
- R4: In capture mode a detected edge on the channel input copies the counter into the channel register and sets the flag at the next edge. The edge kind comes from mode bits {npol,pol}: 00 rising, 01 falling, 11 both. An edge of the other kind has no effect.
- R5: Reading a channel register with `rdEn` clears that channel's flag in capture mode only. In compare mode the read leaves the flag alone.
- R6: A running counter counts up by one per cycle and wraps from the reload value to 0. The wrap sets the update flag only while the update-disable control bit is 0.
- R7: Writing 1 to event bit 0 sets the counter to 0. It sets the update flag only if update-disable and update-source are both 0.
- R8: A one-cycle `extTrig` pulse sets the counter to 0. It sets the update flag under the same condition as R7.
- R9: Event bits 1 to 4 set channel flags 0 to 3. In capture mode they also copy the counter into the channel register. Event bit 6 sets the trigger flag. The event register always reads 0.
- R10: Status is bit 0 update, bits 1 to 4 channels 0 to 3, bit 6 trigger, and bit 5 is always 0. A status write clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R11: When a hardware set and a software clear of the same flag fall on one cycle, the flag ends up set.
- R12: Each interrupt output is high exactly while its flag and the enable bit at the same position in the enable register are both 1.
- R13: The register addresses are 0 control ({source,disable,run} in bits 2:0), 1 interrupt enable, 2 status, 3 events, 4 mode (3 bits per channel, at 3·ch: capture, pol, npol), 5 reload, 6 counter (writable), and 8 to 11 channel registers 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (for clear-on-read) |
| addr | input | 4 | Register address |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data |
| capIn | input | 4 | Channel capture inputs |
| extTrig | input | 1 | External counter restart pulse |
| irqUpd | output | 1 | Update interrupt |
| irqCc | output | 4 | Channel interrupts |
| irqTrg | output | 1 | Trigger interrupt |

## Verification
The bench builds the block with the default 16-bit counter. It programs the reload value to 9, so a full counting period takes ten cycles. That makes the wrap, the compare above reload and the update-disable window visible within a short run. Captures and the event writes are done with the counter stopped at loaded values, so every latched value is known exactly.

// File: rtl/tmrPkg.sv
`timescale 1ns/1ps
package tmrPkg;
  localparam int TMR_CH = 4;
  localparam int ADDR_W = 4;
  localparam int FLAG_W = 7;
  localparam int MODE_W = 3 * TMR_CH;
  localparam int CC_BASE = 8;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_EVGEN  = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_MODE   = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_RELOAD = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 4'h6;

  // flag / event bit positions
  localparam int F_UPD = 0;
  localparam int F_CH0 = 1;
  localparam int F_TRG = 6;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 7'b101_1111;

  // control register bits
  localparam int C_RUN = 0;
  localparam int C_UDIS = 1;
  localparam int C_USRC = 2;

  typedef struct packed {
    logic              reinit;
    logic              cntLoad;
    logic [TMR_CH-1:0] ccLoad;
    logic [TMR_CH-1:0] ccGrab;
  } dpStrobe_t;

  typedef struct packed {
    logic              ovf;
    logic [TMR_CH-1:0] cmpHit;
    logic [TMR_CH-1:0] capHit;
  } dpEvent_t;
endpackage

// File: rtl/tmrDatapath.sv
`timescale 1ns/1ps
module tmrDatapath import tmrPkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobe_t                      strobe,
  input  logic [CNT_W-1:0]               wrData,
  input  logic                           run,
  input  logic [CNT_W-1:0]               reload,
  input  logic [TMR_CH-1:0]              capMode,
  input  logic [2*TMR_CH-1:0]            edgeSel,
  input  logic [TMR_CH-1:0]              capIn,
  output logic [CNT_W-1:0]               cnt,
  output logic [TMR_CH-1:0][CNT_W-1:0]   ccVal,
  output dpEvent_t                       evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              atTop;
  logic [TMR_CH-1:0] capPrev;
  logic [TMR_CH-1:0] capHitV;
  logic [TMR_CH-1:0] cmpHitV;
  logic [TMR_CH-1:0] riseV;
  logic [TMR_CH-1:0] fallV;

  assign atTop = (cnt == reload);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.reinit)   cnt <= '0;
    else if (strobe.cntLoad)  cnt <= wrData;
    else if (run)             cnt <= atTop ? '0 : cnt + ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capPrev <= '0;
    else       capPrev <= capIn;
  end

  assign riseV = capIn & ~capPrev;
  assign fallV = ~capIn & capPrev;

  always_comb begin
    for (int i = 0; i < TMR_CH; i++) begin
      logic hit;
      if (edgeSel[2*i]) hit = edgeSel[2*i+1] ? (riseV[i] | fallV[i]) : fallV[i];
      else              hit = riseV[i];
      capHitV[i] = capMode[i] && hit;
      cmpHitV[i] = !capMode[i] && run &&
                   ((cnt == ccVal[i]) || ((ccVal[i] > reload) && atTop));
    end
  end

  always_comb begin
    evt.ovf    = run && atTop && !strobe.reinit && !strobe.cntLoad;
    evt.cmpHit = cmpHitV;
    evt.capHit = capHitV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccVal <= '0;
    end else begin
      for (int i = 0; i < TMR_CH; i++) begin
        if (capHitV[i] || strobe.ccGrab[i]) ccVal[i] <= cnt;
        else if (strobe.ccLoad[i])          ccVal[i] <= wrData;
      end
    end
  end
endmodule

// File: rtl/tmrCtrl.sv
`timescale 1ns/1ps
module tmrCtrl import tmrPkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [CNT_W-1:0]             wrData,
  input  logic                         extTrig,
  input  dpEvent_t                     evt,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [TMR_CH-1:0][CNT_W-1:0] ccVal,
  output dpStrobe_t                    strobe,
  output logic                         run,
  output logic                         updDis,
  output logic                         urs,
  output logic [CNT_W-1:0]             reload,
  output logic [TMR_CH-1:0]            capMode,
  output logic [2*TMR_CH-1:0]          edgeSel,
  output logic [FLAG_W-1:0]            flags,
  output logic [FLAG_W-1:0]            ien,
  output logic [CNT_W-1:0]             rdData
);
  logic [2:0]        ctrlReg;
  logic [MODE_W-1:0] modeReg;
  logic              evWr;
  logic [TMR_CH-1:0] ccGen;
  logic [FLAG_W-1:0] flagSet;
  logic [FLAG_W-1:0] flagClr;

  assign run    = ctrlReg[C_RUN];
  assign updDis = ctrlReg[C_UDIS];
  assign urs    = ctrlReg[C_USRC];
  assign evWr   = wrEn && (addr == ADR_EVGEN);

  for (genvar g = 0; g < TMR_CH; g++) begin : gMode
    assign capMode[g]       = modeReg[3*g];
    assign edgeSel[2*g]     = modeReg[3*g+1];
    assign edgeSel[2*g+1]   = modeReg[3*g+2];
  end

  // event strobes toward the datapath
  always_comb begin
    strobe         = '0;
    strobe.reinit  = (evWr && wrData[F_UPD]) || extTrig;
    strobe.cntLoad = wrEn && (addr == ADR_COUNT);
    for (int i = 0; i < TMR_CH; i++) begin
      ccGen[i]          = evWr && wrData[F_CH0+i];
      strobe.ccLoad[i]  = wrEn && (addr == ADDR_W'(CC_BASE + i));
      strobe.ccGrab[i]  = ccGen[i] && capMode[i];
    end
  end

  // flag set / clear sources
  always_comb begin
    flagSet = '0;
    flagClr = '0;
    flagSet[F_UPD] = (evt.ovf && !updDis) || (strobe.reinit && !updDis && !urs);
    for (int i = 0; i < TMR_CH; i++) begin
      flagSet[F_CH0+i] = evt.cmpHit[i] || evt.capHit[i] || ccGen[i];
      if (rdEn && (addr == ADDR_W'(CC_BASE + i)) && capMode[i])
        flagClr[F_CH0+i] = 1'b1;
    end
    flagSet[F_TRG] = evWr && wrData[F_TRG];
    if (wrEn && (addr == ADR_STAT)) flagClr = flagClr | ~wrData[FLAG_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      modeReg <= '0;
      ien     <= '0;
      reload  <= '1;
      flags   <= '0;
    end else begin
      if (wrEn && addr == ADR_CTRL)   ctrlReg <= wrData[2:0];
      if (wrEn && addr == ADR_MODE)   modeReg <= wrData[MODE_W-1:0];
      if (wrEn && addr == ADR_IEN)    ien     <= wrData[FLAG_W-1:0] & FLAG_MASK;
      if (wrEn && addr == ADR_RELOAD) reload  <= wrData;
      flags <= ((flags & ~flagClr) | flagSet) & FLAG_MASK;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADR_CTRL:   rdData = CNT_W'(ctrlReg);
      ADR_IEN:    rdData = CNT_W'(ien);
      ADR_STAT:   rdData = CNT_W'(flags);
      ADR_MODE:   rdData = CNT_W'(modeReg);
      ADR_RELOAD: rdData = reload;
      ADR_COUNT:  rdData = cnt;
      default: begin
        for (int i = 0; i < TMR_CH; i++)
          if (addr == ADDR_W'(CC_BASE + i)) rdData = ccVal[i];
      end
    endcase
  end
endmodule

// File: rtl/tmrFlagEvt.sv
`timescale 1ns/1ps
module tmrFlagEvt import tmrPkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wrData,
  output logic [CNT_W-1:0]   rdData,
  input  logic [TMR_CH-1:0]  capIn,
  input  logic               extTrig,
  output logic               irqUpd,
  output logic [TMR_CH-1:0]  irqCc,
  output logic               irqTrg
);
  dpStrobe_t                    strobe;
  dpEvent_t                     evt;
  logic                         runCfg;
  logic                         updDis;
  logic                         urs;
  logic [CNT_W-1:0]             reloadVal;
  logic [CNT_W-1:0]             cntVal;
  logic [TMR_CH-1:0][CNT_W-1:0] ccVal;
  logic [TMR_CH-1:0]            capMode;
  logic [2*TMR_CH-1:0]          edgeSel;
  logic [FLAG_W-1:0]            flagVec;
  logic [FLAG_W-1:0]            ienVec;

  tmrCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .extTrig(extTrig), .evt(evt), .cnt(cntVal),
    .ccVal(ccVal), .strobe(strobe), .run(runCfg), .updDis(updDis),
    .urs(urs), .reload(reloadVal), .capMode(capMode), .edgeSel(edgeSel),
    .flags(flagVec), .ien(ienVec), .rdData(rdData)
  );

  tmrDatapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .run(runCfg), .reload(reloadVal), .capMode(capMode),
    .edgeSel(edgeSel), .capIn(capIn), .cnt(cntVal), .ccVal(ccVal),
    .evt(evt)
  );

  assign irqUpd = flagVec[F_UPD] & ienVec[F_UPD];
  assign irqCc  = flagVec[F_CH0 +: TMR_CH] & ienVec[F_CH0 +: TMR_CH];
  assign irqTrg = flagVec[F_TRG] & ienVec[F_TRG];
endmodule

// File: rtl/tmrFlagEvtChk.sv
`timescale 1ns/1ps
module tmrFlagEvtChk import tmrPkg::*; #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [CNT_W-1:0]   wrData,
  input logic               extTrig,
  input logic [FLAG_W-1:0]  flags,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   cc0,
  input logic               run,
  input logic               capMode0,
  input logic               updDis,
  input logic               urs
);
  a_r9_trg_event: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_EVGEN && wrData[F_TRG]) |=> flags[F_TRG]);

  a_r7_ug_restart: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_EVGEN && wrData[F_UPD]) |=> (cnt == '0));

  a_r2_cmp_match: assert property (@(posedge clk) disable iff (!rstN)
    (run && !capMode0 && cnt == cc0) |=> flags[F_CH0]);

  a_r10_ones_keep: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_STAT && wrData[FLAG_W-1:0] == '1)
      |=> ((flags & $past(flags)) == $past(flags)));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (extTrig && !updDis && !urs) |=> flags[F_UPD]);

  a_r10_resv_zero: assert property (@(posedge clk) disable iff (!rstN)
    !flags[5]);
endmodule

bind tmrFlagEvt tmrFlagEvtChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .extTrig(extTrig), .flags(flagVec), .cnt(cntVal), .cc0(ccVal[0]),
  .run(runCfg), .capMode0(capMode[0]), .updDis(updDis), .urs(urs)
);

// File: tb/sim_tmrFlagEvt.sv
`timescale 1ns/1ps
module sim_tmrFlagEvt;
  localparam int CW = 16;
  localparam logic [3:0] A_CTRL = 4'h0, A_IEN = 4'h1, A_STAT = 4'h2,
    A_EV = 4'h3, A_MODE = 4'h4, A_REL = 4'h5, A_CNT = 4'h6,
    A_CC0 = 4'h8, A_CC1 = 4'h9, A_CC2 = 4'hA, A_CC3 = 4'hB;

  typedef struct packed {
    logic        rd;
    logic [3:0]  a;
    logic [15:0] d;
    logic [15:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{1'b1, A_STAT, 16'h0000, 16'h0000, 4'd1},   // R1
    '{1'b1, A_REL,  16'h0000, 16'hFFFF, 4'd1},   // R1
    '{1'b1, A_CNT,  16'h0000, 16'h0000, 4'd1},   // R1
    '{1'b1, A_CC0,  16'h0000, 16'h0000, 4'd1},   // R1
    '{1'b1, A_CTRL, 16'h0000, 16'h0000, 4'd1},   // R1
    '{1'b0, A_EV,   16'h0040, 16'h0000, 4'd9},
    '{1'b1, A_STAT, 16'h0000, 16'h0040, 4'd9},   // R9 trigger flag
    '{1'b1, A_EV,   16'h0000, 16'h0000, 4'd9},   // R9 reads zero
    '{1'b0, A_EV,   16'h0006, 16'h0000, 4'd9},
    '{1'b1, A_STAT, 16'h0000, 16'h0046, 4'd9},   // R9 ch0/ch1 flags
    '{1'b0, A_STAT, 16'h007D, 16'h0000, 4'd10},
    '{1'b1, A_STAT, 16'h0000, 16'h0044, 4'd10},  // R10 only bit1 cleared
    '{1'b0, A_EV,   16'h0020, 16'h0000, 4'd10},
    '{1'b1, A_STAT, 16'h0000, 16'h0044, 4'd10},  // R10 bit5 stays 0
    '{1'b0, A_STAT, 16'h0000, 16'h0000, 4'd10},
    '{1'b1, A_STAT, 16'h0000, 16'h0000, 4'd10},  // R10
    '{1'b0, A_EV,   16'h0001, 16'h0000, 4'd7},
    '{1'b1, A_STAT, 16'h0000, 16'h0001, 4'd7},   // R7 flag when both 0
    '{1'b0, A_STAT, 16'h0000, 16'h0000, 4'd7},
    '{1'b0, A_CTRL, 16'h0004, 16'h0000, 4'd7},
    '{1'b0, A_EV,   16'h0001, 16'h0000, 4'd7},
    '{1'b1, A_STAT, 16'h0000, 16'h0000, 4'd7},   // R7 source bit blocks
    '{1'b0, A_CTRL, 16'h0002, 16'h0000, 4'd7},
    '{1'b0, A_EV,   16'h0001, 16'h0000, 4'd7},
    '{1'b1, A_STAT, 16'h0000, 16'h0000, 4'd7},   // R7 disable bit blocks
    '{1'b0, A_CNT,  16'h0005, 16'h0000, 4'd13},
    '{1'b1, A_CNT,  16'h0000, 16'h0005, 4'd13},  // R13 counter writable
    '{1'b0, A_EV,   16'h0001, 16'h0000, 4'd7},
    '{1'b1, A_CNT,  16'h0000, 16'h0000, 4'd7},   // R7 counter restart
    '{1'b0, A_REL,  16'h0009, 16'h0000, 4'd13},
    '{1'b1, A_REL,  16'h0000, 16'h0009, 4'd13}   // R13
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [3:0]    addr = '0;
  logic [CW-1:0] wrData = '0;
  logic [CW-1:0] rdData;
  logic [3:0]    capIn = '0;
  logic          extTrig = 1'b0;
  logic          irqUpd;
  logic [3:0]    irqCc;
  logic          irqTrg;
  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  tmrFlagEvt #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .capIn(capIn), .extTrig(extTrig),
    .irqUpd(irqUpd), .irqCc(irqCc), .irqTrg(irqTrg)
  );

  task automatic chk(input int req, input logic [15:0] got, input logic [15:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge, one cycle each
  task automatic busWr(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [15:0] d);
    rdEn = 1'b1; addr = a;
    #2 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdChk(input int req, input logic [3:0] a, input logic [15:0] mask,
                       input logic [15:0] exp);
    logic [15:0] v;
    busRd(a, v);
    chk(req, v & mask, exp);
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1000000;
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);
    chk(1, {13'd0, irqUpd, irqTrg, |irqCc}, 16'h0);   // R1 irqs low

    for (int k = 0; k < NV; k++) begin
      if (TBL[k].rd) begin
        busRd(TBL[k].a, v);
        chk(int'(TBL[k].r), v, TBL[k].e);
      end else begin
        busWr(TBL[k].a, TBL[k].d);
      end
    end
    rdChk(13, A_CTRL, 16'hFFFF, 16'h0002);                // R13

    // counting: reload 9, cc0 = 3, cc1 = 20 (above reload)
    busWr(A_CC0, 16'd3);
    busWr(A_CC1, 16'd20);
    busWr(A_CC2, 16'd100);
    busWr(A_CC3, 16'd100);
    busWr(A_IEN, 16'h0003);
    busWr(A_CTRL, 16'h0001);
    waitCyc(3);
    rdChk(6, A_CNT, 16'hFFFF, 16'd3);                     // R6 count
    rdChk(2, A_STAT, 16'h0007, 16'h0002);                 // R2, R3 not yet
    chk(12, {15'd0, irqCc[0]}, 16'h1);                    // R12
    chk(12, {15'd0, irqUpd}, 16'h0);                      // R12
    waitCyc(5);
    rdChk(3, A_STAT, 16'h0007, 16'h0007);                 // R3, R6 wrap flag
    chk(12, {15'd0, irqUpd}, 16'h1);                      // R12
    chk(12, {12'd0, irqCc}, 16'h1);                       // R12 ch1 not enabled
    rdChk(6, A_CNT, 16'hFFFF, 16'd1);                     // R6 wrapped to 0
    busWr(A_CTRL, 16'h0003);
    busWr(A_STAT, 16'h0000);
    waitCyc(12);
    rdChk(6, A_STAT, 16'h0001, 16'h0000);                 // R6 disabled
    busWr(A_CTRL, 16'h0000);

    // trigger interrupt gating
    busWr(A_IEN, 16'h0000);
    busWr(A_EV, 16'h0040);
    chk(12, {15'd0, irqTrg}, 16'h0);                      // R12
    busWr(A_IEN, 16'h0040);
    chk(12, {15'd0, irqTrg}, 16'h1);                      // R12

    // capture, counter stopped
    busWr(A_STAT, 16'h0000);
    busWr(A_MODE, 16'h0040);
    busWr(A_CNT, 16'h1234);
    capIn[2] = 1'b1; @(negedge clk);
    rdChk(4, A_STAT, 16'h0008, 16'h0008);                 // R4 rising
    rdChk(4, A_CC2, 16'hFFFF, 16'h1234);                  // R4
    rdChk(5, A_STAT, 16'h0008, 16'h0000);                 // R5 read clears
    busWr(A_MODE, 16'h00C0);
    busWr(A_CNT, 16'h0055);
    capIn[2] = 1'b0; @(negedge clk);
    rdChk(4, A_STAT, 16'h0008, 16'h0008);                 // R4 falling
    rdChk(4, A_CC2, 16'hFFFF, 16'h0055);                  // R4
    busWr(A_CNT, 16'h0066);
    capIn[2] = 1'b1; @(negedge clk);
    rdChk(4, A_STAT, 16'h0008, 16'h0000);                 // R4 rising ignored
    rdChk(4, A_CC2, 16'hFFFF, 16'h0055);                  // R4 unchanged
    busWr(A_MODE, 16'h01C0);
    busWr(A_CNT, 16'h0077);
    capIn[2] = 1'b0; @(negedge clk);
    rdChk(4, A_CC2, 16'hFFFF, 16'h0077);                  // R4 both edges

    // compare-mode read keeps flag
    busWr(A_MODE, 16'h0000);
    busWr(A_STAT, 16'h0000);
    busWr(A_EV, 16'h0010);
    rdChk(5, A_CC3, 16'hFFFF, 16'd100);
    rdChk(5, A_STAT, 16'h0010, 16'h0010);                 // R5
    // event bit on a capture channel copies counter
    busWr(A_MODE, 16'h0040);
    busWr(A_CNT, 16'h0099);
    busWr(A_EV, 16'h0008);
    rdChk(9, A_STAT, 16'h0008, 16'h0008);                 // R9
    rdChk(9, A_CC2, 16'hFFFF, 16'h0099);                  // R9 copy

    // external trigger
    busWr(A_STAT, 16'h0000);
    busWr(A_CNT, 16'h0040);
    extTrig = 1'b1; @(negedge clk); extTrig = 1'b0;
    rdChk(8, A_CNT, 16'hFFFF, 16'h0000);                  // R8
    rdChk(8, A_STAT, 16'h0001, 16'h0001);                 // R8
    busWr(A_STAT, 16'h0000);
    busWr(A_CTRL, 16'h0004);
    busWr(A_CNT, 16'h0040);
    extTrig = 1'b1; @(negedge clk); extTrig = 1'b0;
    rdChk(8, A_CNT, 16'hFFFF, 16'h0000);                  // R8
    rdChk(8, A_STAT, 16'h0001, 16'h0000);                 // R8 blocked

    // set and clear on the same edge
    busWr(A_CTRL, 16'h0000);
    extTrig = 1'b1;
    busWr(A_STAT, 16'h0000);
    extTrig = 1'b0;
    rdChk(11, A_STAT, 16'h0001, 16'h0001);                // R11

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule